// File: doc/BRIEF.md
# LVDS Lane Bit Mapper

This block sits between the display pipelines and a 7:1 serial transmitter. Each pixel holds 24 data bits plus horizontal sync, vertical sync and data-enable. The block takes one pixel from one of three sources and turns it into five serial lanes of seven bits each. A 35-bit candidate vector is built from the chosen pixel, with the sync and enable bits passed through a polarity stage and a few constant bits added. Each of the 35 lane slots then picks one bit of that vector.

Slots can follow one of two fixed 24-bit packings, or a location mode in which every slot has its own 6-bit index register. Per-slot mask bits can force any slot to zero. A single-cycle write port sets the index, mask, polarity and control registers. The serializer advances one slot on each `bit_en` pulse, which is the 7x bit-rate enable. Every seventh pulse it takes a complete new frame, so a change to the settings can only show up at a pixel boundary.

Top module: `lvds_lane_mapper`

## Requirements
- R1: After reset `lane_out` and `frame_sync` are 0. The registers hold their reset values: every index field is 27, every mask bit is 1, no polarity inversion, source 0, and the first fixed packing (format code 0).
- R2: The candidate vector is laid out as follows. Bits 23:0 are pixel data, bit 24 is hsync, bit 25 is vsync and bit 26 is data-enable. Bits 30:27 are 0 and bits 34:31 are 1. An index of 35 to 63 gives 0.
- R3: In location mode (format code 2), slot k of lane L is slot number n = 7L+k, with lanes A..E as L = 0..4. It outputs the candidate bit chosen by field n. Field n sits in register n/5 (addresses 0..6), at bits [6(n%5)+5 : 6(n%5)].
- R4: Format code 0 uses a fixed packing with red = data[7:0], green = data[15:8] and blue = data[23:16]. Slots 0..6 of each lane carry: lane A R2..R7,G2; lane B G3..G7,B2,B3; lane C B4..B7,HS,VS,DE; lane D R0,R1,G0,G1,B0,B1,0; lane E all 0.
- R5: Format code 1 uses the other fixed packing, with the same color layout. Slots 0..6 carry: lane A R0..R5,G0; lane B G1..G5,B0,B1; lane C B2..B5,HS,VS,DE; lane D R6,R7,G6,G7,B6,B7,0; lane E all 0.
- R6: The control register is at address 10. Bits 1:0 select the source (0..2) and bits 3:2 select the format. A source code of 3 or a format code of 3 leaves that field unchanged. Source s is `src_pixel[27s+26:27s]`, arranged as {de, vs, hs, data[23:0]}.
- R7: The polarity register is at address 9. Bit 0 inverts hsync, bit 1 inverts vsync and bit 2 inverts data-enable, each before it enters the candidate vector.
- R8: Mask bit n is at address 7 bit n for n < 32, and at address 8 bit n-32 for n ≥ 32. A cleared mask bit forces slot n to 0 in every format.
- R9: A `bit_en` pulse loads a new frame when the slot position is 0: the first pulse after reset, and every seventh pulse after that. Lanes send slot 6 first and then one lower slot per pulse. `frame_sync` is 1 exactly while slot 6 is on the lanes.
- R10: While `bit_en` is low, `lane_out` and `frame_sync` hold their values.
- R11: Register writes and pixel input changes made during a frame do not alter that frame. They appear in the next frame that loads.
- R12: Writes to addresses 11..15 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | One pulse per serial bit slot |
| src_pixel | input | 81 | Three sources of 27 bits each: {de, vs, hs, data} |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Register write data |
| lane_out | output | 5 | Serial bit for lanes A..E (bit 0 = A) |
| frame_sync | output | 1 | High while slot 6 of a frame is on the lanes |

## Verification
A register write takes effect at the rising edge on which `reg_wr` is high. Its effect is first seen in the frame loaded by the next `bit_en` edge at slot position 0. The load edge puts slot 6 on the lanes at once, and each later enabled edge moves down one slot. The bench raises `bit_en` for exactly one rising edge per step. It reads the lanes on the following falling edge, so each sample matches a known slot. For the boundary checks it stops mid-frame, writes registers and changes pixels, and confirms that the lanes hold. The rest of that frame must still match the old settings, and the next frame must match the new ones.

// File: rtl/lvds_map_pkg.sv
package lvds_map_pkg;

    parameter int PIX_W          = 24;
    parameter int SRC_W          = PIX_W + 3;
    parameter int NSRC           = 3;
    parameter int SRC_SEL_W      = 2;
    parameter int LANES          = 5;
    parameter int SLOTS          = 7;
    parameter int NUM_SLOTS      = LANES * SLOTS;
    parameter int IDX_W          = 6;
    parameter int CAND_W         = 35;
    parameter int N_ZERO         = 4;
    parameter int N_ONE          = CAND_W - PIX_W - 3 - N_ZERO;
    parameter int EXT_W          = 2 ** IDX_W;
    parameter int REG_W          = 32;
    parameter int ADDR_W         = 4;
    parameter int FIELDS_PER_REG = REG_W / IDX_W;
    parameter int LOC_REGS       = (NUM_SLOTS + FIELDS_PER_REG - 1) / FIELDS_PER_REG;
    parameter int POS_W          = $clog2(SLOTS);

    parameter logic [ADDR_W-1:0] A_MASK_LO = ADDR_W'(LOC_REGS);
    parameter logic [ADDR_W-1:0] A_MASK_HI = ADDR_W'(LOC_REGS + 1);
    parameter logic [ADDR_W-1:0] A_POL     = ADDR_W'(LOC_REGS + 2);
    parameter logic [ADDR_W-1:0] A_CTL     = ADDR_W'(LOC_REGS + 3);

    parameter logic [IDX_W-1:0] IDX_ZERO = IDX_W'(PIX_W + 3);

    typedef enum logic [1:0] {
        FMT_PACK_A = 2'd0,
        FMT_PACK_B = 2'd1,
        FMT_LOC    = 2'd2
    } fmt_e;

    typedef struct packed {
        logic [NUM_SLOTS-1:0][IDX_W-1:0] loc;
        logic [NUM_SLOTS-1:0]            mask;
        logic [2:0]                      pol;
        logic [SRC_SEL_W-1:0]            src;
        fmt_e                            fmt;
    } cfg_t;

    typedef struct packed {
        logic [POS_W-1:0]     pos;
        logic [NUM_SLOTS-1:0] frame;
    } ser_t;

    // Fixed packings: candidate index for a lane/slot pair.
    function automatic logic [IDX_W-1:0] fixed_index(input logic pack_b,
                                                     input int lane,
                                                     input int slot);
        int t [7];
        t = '{27, 27, 27, 27, 27, 27, 27};
        if (pack_b) begin
            case (lane)
                0: t = '{0, 1, 2, 3, 4, 5, 8};
                1: t = '{9, 10, 11, 12, 13, 16, 17};
                2: t = '{18, 19, 20, 21, 24, 25, 26};
                3: t = '{6, 7, 14, 15, 22, 23, 27};
                default: ;
            endcase
        end else begin
            case (lane)
                0: t = '{2, 3, 4, 5, 6, 7, 10};
                1: t = '{11, 12, 13, 14, 15, 18, 19};
                2: t = '{20, 21, 22, 23, 24, 25, 26};
                3: t = '{0, 1, 8, 9, 16, 17, 27};
                default: ;
            endcase
        end
        return IDX_W'(t[slot]);
    endfunction

endpackage

// File: rtl/lvds_map_regs.sv
module lvds_map_regs
    import lvds_map_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    output cfg_t              cfg
);

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            for (int r = 0; r < LOC_REGS; r++) begin
                if (wr_addr == ADDR_W'(r)) begin
                    for (int f = 0; f < FIELDS_PER_REG; f++) begin
                        if (r * FIELDS_PER_REG + f < NUM_SLOTS) begin
                            cfg_d.loc[r * FIELDS_PER_REG + f] = wr_data[f * IDX_W +: IDX_W];
                        end
                    end
                end
            end
            if (wr_addr == A_MASK_LO) begin
                cfg_d.mask[REG_W-1:0] = wr_data;
            end
            if (wr_addr == A_MASK_HI) begin
                cfg_d.mask[NUM_SLOTS-1:REG_W] = wr_data[NUM_SLOTS-REG_W-1:0];
            end
            if (wr_addr == A_POL) begin
                cfg_d.pol = wr_data[2:0];
            end
            if (wr_addr == A_CTL) begin
                if (wr_data[SRC_SEL_W-1:0] < SRC_SEL_W'(NSRC)) begin
                    cfg_d.src = wr_data[SRC_SEL_W-1:0];
                end
                if (wr_data[3:2] != 2'd3) begin
                    cfg_d.fmt = fmt_e'(wr_data[3:2]);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int n = 0; n < NUM_SLOTS; n++) begin
                cfg_q.loc[n] <= IDX_ZERO;
            end
            cfg_q.mask <= '1;
            cfg_q.pol  <= '0;
            cfg_q.src  <= '0;
            cfg_q.fmt  <= FMT_PACK_A;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg = cfg_q;

    // R6
    src_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.src < SRC_SEL_W'(NSRC));

    // R6
    fmt_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.fmt inside {FMT_PACK_A, FMT_PACK_B, FMT_LOC});

endmodule

// File: rtl/lvds_slot_xbar.sv
module lvds_slot_xbar
    import lvds_map_pkg::*;
(
    input  logic [NSRC*SRC_W-1:0] src_pixel,
    input  cfg_t                  cfg,
    output logic [NUM_SLOTS-1:0]  slot_bits
);

    logic [SRC_W-1:0]  pix;
    logic [EXT_W-1:0]  cand_ext;

    always_comb begin
        pix = '0;
        for (int s = 0; s < NSRC; s++) begin
            if (cfg.src == SRC_SEL_W'(s)) begin
                pix = src_pixel[s * SRC_W +: SRC_W];
            end
        end
    end

    // Indices beyond the candidate vector land in the zero padding.
    always_comb begin
        cand_ext = '0;
        cand_ext[CAND_W-1:0] = {{N_ONE{1'b1}}, {N_ZERO{1'b0}},
                                pix[PIX_W+2] ^ cfg.pol[2],
                                pix[PIX_W+1] ^ cfg.pol[1],
                                pix[PIX_W]   ^ cfg.pol[0],
                                pix[PIX_W-1:0]};
    end

    for (genvar n = 0; n < NUM_SLOTS; n++) begin : g_slot
        localparam logic [IDX_W-1:0] IDX_A = fixed_index(1'b0, n / SLOTS, n % SLOTS);
        localparam logic [IDX_W-1:0] IDX_B = fixed_index(1'b1, n / SLOTS, n % SLOTS);
        logic [IDX_W-1:0] idx;
        always_comb begin
            case (cfg.fmt)
                FMT_LOC:    idx = cfg.loc[n];
                FMT_PACK_B: idx = IDX_B;
                default:    idx = IDX_A;
            endcase
        end
        assign slot_bits[n] = cand_ext[idx] & cfg.mask[n];
    end

endmodule

// File: rtl/lvds_lane_ser.sv
module lvds_lane_ser
    import lvds_map_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bit_en,
    input  logic [NUM_SLOTS-1:0] slot_bits,
    output logic [LANES-1:0]     lane_out,
    output logic                 frame_sync
);

    ser_t ser_d, ser_q;

    always_comb begin
        ser_d = ser_q;
        if (bit_en) begin
            if (ser_q.pos == '0) begin
                ser_d.frame = slot_bits;
                ser_d.pos   = POS_W'(SLOTS - 1);
            end else begin
                ser_d.pos = ser_q.pos - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ser_q <= '0;
        end else begin
            ser_q <= ser_d;
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [SLOTS-1:0] word;
        assign word        = ser_q.frame[l * SLOTS +: SLOTS];
        assign lane_out[l] = word[ser_q.pos];
    end

    assign frame_sync = (ser_q.pos == POS_W'(SLOTS - 1));

    // R10
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> ($stable(lane_out) && $stable(frame_sync)));

    // R9
    sync_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && frame_sync) |=> !frame_sync);

    // R11
    mid_frame_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && ser_q.pos != '0) |=> $stable(ser_q.frame));

endmodule

// File: rtl/lvds_lane_mapper.sv
module lvds_lane_mapper
    import lvds_map_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bit_en,
    input  logic [NSRC*SRC_W-1:0] src_pixel,
    input  logic                  reg_wr,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [REG_W-1:0]      reg_wdata,
    output logic [LANES-1:0]      lane_out,
    output logic                  frame_sync
);

    cfg_t                 cfg;
    logic [NUM_SLOTS-1:0] slot_bits;

    lvds_map_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr),
        .wr_addr (reg_addr),
        .wr_data (reg_wdata),
        .cfg     (cfg)
    );

    lvds_slot_xbar u_xbar (
        .src_pixel (src_pixel),
        .cfg       (cfg),
        .slot_bits (slot_bits)
    );

    lvds_lane_ser u_ser (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_en     (bit_en),
        .slot_bits  (slot_bits),
        .lane_out   (lane_out),
        .frame_sync (frame_sync)
    );

endmodule

// File: tb/tb_lvds_lane_mapper.sv
module tb_lvds_lane_mapper;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_en = 1'b0;
    logic [80:0] src_pixel = '0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [4:0]  lane_out;
    logic        frame_sync;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    lvds_lane_mapper dut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .src_pixel(src_pixel),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .lane_out(lane_out), .frame_sync(frame_sync)
    );

    // Slot n = 7*lane + slot, from R4 and R5.
    localparam int TAB_A [35] = '{2, 3, 4, 5, 6, 7, 10,  11, 12, 13, 14, 15, 18, 19,
                                  20, 21, 22, 23, 24, 25, 26,  0, 1, 8, 9, 16, 17, 27,
                                  27, 27, 27, 27, 27, 27, 27};
    localparam int TAB_B [35] = '{0, 1, 2, 3, 4, 5, 8,  9, 10, 11, 12, 13, 16, 17,
                                  18, 19, 20, 21, 24, 25, 26,  6, 7, 14, 15, 22, 23, 27,
                                  27, 27, 27, 27, 27, 27, 27};

    typedef struct packed {
        logic [1:0]  fmt;
        logic [1:0]  src;
        logic [2:0]  pol;
        logic [2:0]  ctl;
        logic [23:0] data;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{2'd0, 2'd0, 3'b000, 3'b101, 24'h123456},
        '{2'd0, 2'd1, 3'b111, 3'b010, 24'hA5C3F0},
        '{2'd1, 2'd2, 3'b000, 3'b111, 24'h0F1E2D},
        '{2'd1, 2'd0, 3'b010, 3'b000, 24'hFFFFFF},
        '{2'd2, 2'd1, 3'b000, 3'b110, 24'h5A5A5A},
        '{2'd2, 2'd2, 3'b101, 3'b011, 24'h000000},
        '{2'd2, 2'd0, 3'b000, 3'b100, 24'h89ABCD},
        '{2'd1, 2'd1, 3'b100, 3'b001, 24'h700001}
    };

    // Bench-side register model
    int          m_loc [35];
    logic [34:0] m_mask;
    logic [2:0]  m_pol;
    int          m_src;
    int          m_fmt;

    function automatic logic [34:0] exp_frame();
        logic [26:0] p;
        logic [63:0] cand;
        logic [34:0] r;
        int idx;
        p = src_pixel[m_src*27 +: 27];
        cand = '0;
        cand[23:0]  = p[23:0];
        cand[24]    = p[24] ^ m_pol[0];
        cand[25]    = p[25] ^ m_pol[1];
        cand[26]    = p[26] ^ m_pol[2];
        cand[34:31] = 4'hF;
        for (int n = 0; n < 35; n++) begin
            idx  = (m_fmt == 2) ? m_loc[n] : ((m_fmt == 1) ? TAB_B[n] : TAB_A[n]);
            r[n] = (idx < 35) ? (cand[idx] & m_mask[n]) : 1'b0;
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [34:0] act, input logic [34:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 4'(a); reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
        if (a < 7) begin
            for (int f = 0; f < 5; f++) m_loc[a*5+f] = int'(v[f*6 +: 6]);
        end else if (a == 7) m_mask[31:0] = v;
        else if (a == 8) m_mask[34:32] = v[2:0];
        else if (a == 9) m_pol = v[2:0];
        else if (a == 10) begin
            if (v[1:0] != 2'd3) m_src = int'(v[1:0]);
            if (v[3:2] != 2'd3) m_fmt = int'(v[3:2]);
        end
    endtask

    task automatic set_sources(input logic [23:0] data, input logic [2:0] ctl);
        for (int s = 0; s < 3; s++)
            src_pixel[s*27 +: 27] = {ctl ^ 3'(s), data + 24'(s) * 24'h111111};
    endtask

    // One enabled edge, then sample slot k of every lane at the next falling edge.
    task automatic step(input int k, inout logic [34:0] got, inout bit sync_ok);
        @(negedge clk); bit_en = 1'b1;
        @(negedge clk); bit_en = 1'b0;
        for (int l = 0; l < 5; l++) got[l*7+k] = lane_out[l];
        sync_ok &= (k == 6) ? frame_sync : !frame_sync;
    endtask

    task automatic run_frame(input string tag);
        logic [34:0] got, exp;
        bit sync_ok;
        got = '0; sync_ok = 1'b1;
        exp = exp_frame();
        for (int k = 6; k >= 0; k--) step(k, got, sync_ok);
        check(got == exp, tag, got, exp);
        check(sync_ok, "R9 frame_sync placement", 35'(sync_ok), 35'd1);
    endtask

    task automatic program_loc();
        int pat [35];
        int lc [7];
        logic [31:0] v;
        lc = '{26, 25, 24, 34, 24, 25, 26};
        for (int n = 0; n < 35; n++) pat[n] = (n * 11 + 5) % 35;
        for (int k = 0; k < 7; k++) pat[14+k] = lc[k];
        pat[33] = 40;
        pat[34] = 63;
        for (int r = 0; r < 7; r++) begin
            v = '0;
            for (int f = 0; f < 5; f++) v[f*6 +: 6] = 6'(pat[r*5+f]);
            wr(r, v);
        end
    endtask

    initial begin
        #1500000;
        if (!done) begin
            errors++;
            $display("FAIL R9 watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [34:0] got, exp_old;
        logic [4:0]  held;
        bit sync_ok;
        bit hold_ok;
        string tag;

        for (int n = 0; n < 35; n++) m_loc[n] = 27;
        m_mask = '1; m_pol = '0; m_src = 0; m_fmt = 0;

        repeat (3) @(negedge clk);
        check(lane_out == 5'd0, "R1 reset lane_out", 35'(lane_out), 35'd0);
        check(frame_sync == 1'b0, "R1 reset frame_sync", 35'(frame_sync), 35'd0);
        rst_n = 1'b1;
        set_sources(24'hC3A512, 3'b111);
        run_frame("R1 R4 default packing from source 0");
        wr(10, 32'h8);
        run_frame("R1 reset index fields give zero");

        program_loc();

        // R3 R4 R5 R6 R7: table walk
        for (int i = 0; i < 8; i++) begin
            wr(10, {28'd0, VECS[i].fmt, VECS[i].src});
            wr(9, {29'd0, VECS[i].pol});
            set_sources(VECS[i].data, VECS[i].ctl);
            tag = (VECS[i].fmt == 2'd2) ? "R3 R2 R6 R7 location" :
                  (VECS[i].fmt == 2'd1) ? "R5 R6 R7 packing B" : "R4 R6 R7 packing A";
            run_frame(tag);
        end

        // R8: masks in location mode and fixed mode
        wr(10, 32'h8);
        wr(9, 0);
        wr(7, 32'hAAAA5555);
        wr(8, 32'h5);
        set_sources(24'hFFFFFF, 3'b111);
        run_frame("R8 mask in location mode");
        wr(10, 32'h4);
        run_frame("R8 mask in packing B");
        wr(7, 32'hFFFFFFFF);
        wr(8, 32'h7);

        // R6: illegal source and format codes are ignored
        wr(10, 32'h6);
        set_sources(24'h3C5A96, 3'b010);
        wr(10, 32'hF);
        run_frame("R6 illegal codes ignored");

        // R12: unmapped addresses
        wr(12, 32'hFFFFFFFF);
        wr(15, 32'h0);
        wr(11, 32'h0);
        run_frame("R12 unmapped writes ignored");

        // R11 R10: changes in the middle of a frame
        wr(10, 32'h8);
        set_sources(24'h13579B, 3'b001);
        exp_old = exp_frame();
        got = '0; sync_ok = 1'b1;
        for (int k = 6; k >= 4; k--) step(k, got, sync_ok);
        held = lane_out;
        wr(9, 32'h7);
        wr(2, 32'h0);
        wr(10, 32'h1);
        set_sources(24'hEDCBA9, 3'b110);
        hold_ok = 1'b1;
        repeat (3) begin
            @(negedge clk);
            hold_ok &= (lane_out == held) && (frame_sync == 1'b0);
        end
        check(hold_ok, "R10 lanes hold while bit_en low", 35'(lane_out), 35'(held));
        for (int k = 3; k >= 0; k--) step(k, got, sync_ok);
        check(got == exp_old, "R11 current frame unaffected", got, exp_old);
        check(sync_ok, "R9 frame_sync placement", 35'(sync_ok), 35'd1);
        run_frame("R11 changes land in next frame");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule